// File: doc/BRIEF.md
# Per-Queue Packet Ready Tracker

The tracker sits beside a multi-queue buffer whose write and read ports carry 36-bit words. On each word, the two most significant bits act as packet markers: bit 35 marks the last word of a packet and bit 34 marks the first. The tracker watches these markers as words enter and leave up to four queues. It does not store data. For each queue it keeps a count of complete packets, meaning an opening marker followed, at that point or later, by a closing marker. The count is held until those packets have been read out.

A queue is "ready" when its count is non-zero. The flag of the queue currently addressed for reading appears on a single output. When packet mode is on, the per-queue flags also replace the almost-empty status bus. When packet mode is off, that bus carries the almost-empty vector supplied from outside. A partial reset addressed to one queue clears that queue's state. Packet length is not limited. Packet mode is only meaningful when both ports are 36 bits wide.

Top module: `pkt_ready_tracker`

## Requirements
- R1: After reset every queue count is zero, so `rd_pkt_rdy` is 0 and, with `pkt_mode`=1, `stat_vec` is all zeros.
- R2: A write whose marker field has the end bit set (`wr_mark[1]`, word bit 35) completes a packet when the same word carries the start bit (`wr_mark[0]`, word bit 34) or when a start was written earlier to that queue with no end since. The completed packet raises that queue's count by one, and the flag shows this from the cycle after the write edge.
- R3: An end marker written to a queue that has no open packet, and words without markers, leave that queue's count unchanged.
- R4: A read on `rd_mark` completes a packet under the same start/end rule as R2, tracked separately per queue on the read side. It lowers that queue's count by one, and the flag falls when the count reaches zero.
- R5: A completing write and a completing read on the same queue in the same cycle leave that queue's count unchanged.
- R6: A count saturates at 2^CNT_W-1, and further completions are not counted. A completing read at count zero is ignored and the count does not wrap.
- R7: `rd_pkt_rdy` equals the ready flag of queue `rd_q` when `pkt_mode`=1 and is 0 when `pkt_mode`=0.
- R8: With `pkt_mode`=1, `stat_vec[i]` is the ready flag of queue i. With `pkt_mode`=0, `stat_vec` equals `ae_in`.
- R9: `prst_en` clears the count and both open-packet states of queue `prst_q` only. It takes priority over any write or read on that queue in the same cycle.
- R10: Traffic on one queue never changes the count of another queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_mode | input | 1 | Packet mode select |
| wr_en | input | 1 | Write strobe |
| wr_q | input | 2 | Queue addressed by the write |
| wr_mark | input | 2 | Written word bits 35:34 (bit1 end, bit0 start) |
| rd_en | input | 1 | Read strobe |
| rd_q | input | 2 | Queue addressed for reading |
| rd_mark | input | 2 | Read word bits 35:34 (bit1 end, bit0 start) |
| prst_en | input | 1 | Partial reset strobe |
| prst_q | input | 2 | Queue to partially reset |
| ae_in | input | 4 | Almost-empty vector used when packet mode is off |
| rd_pkt_rdy | output | 1 | Ready flag of the read-selected queue |
| stat_vec | output | 4 | Per-queue status bus |

## Verification
Every count change lands on the clock edge that samples the strobe, so the flags and the status bus reflect a write, read or partial reset exactly one edge later. The mode and address selects act combinationally on the registered counts. The bench drives each vector on the falling edge, lets one rising edge pass, and then compares both outputs on the next falling edge against a model updated for that same edge. In this way each result is read in the cycle it first becomes due. It runs with 3-bit counters, so saturation and floor cases are reached in a few writes.

// File: rtl/pkt_trk_pkg.sv
package pkt_trk_pkg;
  // positions inside the two-bit marker field (word bits 35:34)
  localparam int MARK_EOP = 1;
  localparam int MARK_SOP = 0;
  localparam int MARK_W   = 2;
endpackage

// File: rtl/pkt_mark_filter.sv
module pkt_mark_filter #(
  parameter int NUM_Q = 4,
  parameter int QW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [QW-1:0]    q,
  input  logic             sop,
  input  logic             eop,
  input  logic [NUM_Q-1:0] clr,
  output logic [NUM_Q-1:0] done
);
  logic [NUM_Q-1:0] open_q;
  logic [NUM_Q-1:0] open_d;
  logic [NUM_Q-1:0] open_en;
  logic [NUM_Q-1:0] hit;

  for (genvar i = 0; i < NUM_Q; i++) begin : g_q
    assign hit[i] = en && (q == QW'(i));

    // completion: end marker closing a packet opened earlier or on this word
    assign done[i] = hit[i] && eop && (sop || open_q[i]);

    always_comb begin
      open_en[i] = clr[i] || hit[i];
      open_d[i]  = open_q[i];
      if (clr[i])        open_d[i] = 1'b0;
      else if (hit[i]) begin
        if (eop)         open_d[i] = 1'b0;
        else if (sop)    open_d[i] = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          open_q[i] <= 1'b0;
      else if (open_en[i]) open_q[i] <= open_d[i];
    end

    // R3: an end marker always leaves the queue with no open packet
    a_r3_close_on_end: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[i] && eop && !clr[i]) |=> !open_q[i]);
    // R2: a lone start marker opens a packet
    a_r2_open_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[i] && sop && !eop && !clr[i]) |=> open_q[i]);
    // R9: partial reset drops an open packet
    a_r9_clear_open: assert property (@(posedge clk) disable iff (!rst_n)
      clr[i] |=> !open_q[i]);
  end
endmodule

// File: rtl/pkt_q_counter.sv
module pkt_q_counter #(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  input  logic clr,
  output logic ready
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr || (inc ^ dec);
    cnt_d  = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (inc && !dec) begin
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end else if (dec && !inc) begin
      if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ready = (cnt_q != '0);

  a_r2_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec && !clr && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r5_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec && !clr) |=> $stable(cnt_q));
  a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec && !clr && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc && !clr && cnt_q == '0) |=> cnt_q == '0);
  a_r9_clear_count: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);
endmodule

// File: rtl/pkt_ready_tracker.sv
module pkt_ready_tracker
  import pkt_trk_pkg::*;
#(
  parameter int NUM_Q = 4,
  parameter int CNT_W = 8,
  localparam int QW   = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_mode,
  input  logic              wr_en,
  input  logic [QW-1:0]     wr_q,
  input  logic [MARK_W-1:0] wr_mark,
  input  logic              rd_en,
  input  logic [QW-1:0]     rd_q,
  input  logic [MARK_W-1:0] rd_mark,
  input  logic              prst_en,
  input  logic [QW-1:0]     prst_q,
  input  logic [NUM_Q-1:0]  ae_in,
  output logic              rd_pkt_rdy,
  output logic [NUM_Q-1:0]  stat_vec
);
  logic [NUM_Q-1:0] clr_vec;
  logic [NUM_Q-1:0] wr_done;
  logic [NUM_Q-1:0] rd_done;
  logic [NUM_Q-1:0] ready_vec;

  for (genvar i = 0; i < NUM_Q; i++) begin : g_clr
    assign clr_vec[i] = prst_en && (prst_q == QW'(i));
  end

  pkt_mark_filter #(.NUM_Q(NUM_Q), .QW(QW)) u_wr_filt (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (wr_en),
    .q    (wr_q),
    .sop  (wr_mark[MARK_SOP]),
    .eop  (wr_mark[MARK_EOP]),
    .clr  (clr_vec),
    .done (wr_done)
  );

  pkt_mark_filter #(.NUM_Q(NUM_Q), .QW(QW)) u_rd_filt (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (rd_en),
    .q    (rd_q),
    .sop  (rd_mark[MARK_SOP]),
    .eop  (rd_mark[MARK_EOP]),
    .clr  (clr_vec),
    .done (rd_done)
  );

  for (genvar i = 0; i < NUM_Q; i++) begin : g_cnt
    pkt_q_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (wr_done[i]),
      .dec  (rd_done[i]),
      .clr  (clr_vec[i]),
      .ready(ready_vec[i])
    );
  end

  always_comb begin
    rd_pkt_rdy = pkt_mode && ready_vec[rd_q];
    stat_vec   = pkt_mode ? ready_vec : ae_in;
  end

  // R7: the selected flag and the status bus agree in packet mode
  a_r7_sel_matches_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_mode && rd_pkt_rdy) |-> stat_vec[rd_q]);
  // R10: an idle queue keeps its flag
  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !rd_en && !prst_en) |=> $stable(ready_vec));
endmodule

// File: tb/pkt_ready_tracker_test.sv
module pkt_ready_tracker_test;
  localparam int NQ = 4;
  localparam int CW = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pkt_mode;
  logic       wr_en, rd_en, prst_en;
  logic [1:0] wr_q, rd_q, prst_q;
  logic [1:0] wr_mark, rd_mark;
  logic [3:0] ae_in;
  logic       rd_pkt_rdy;
  logic [3:0] stat_vec;

  int vectors = 0;
  int errors  = 0;
  int m_cnt[NQ];
  bit m_wopen[NQ];
  bit m_ropen[NQ];

  always #10 clk = ~clk;

  pkt_ready_tracker #(.NUM_Q(NQ), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .pkt_mode(pkt_mode),
    .wr_en(wr_en), .wr_q(wr_q), .wr_mark(wr_mark),
    .rd_en(rd_en), .rd_q(rd_q), .rd_mark(rd_mark),
    .prst_en(prst_en), .prst_q(prst_q), .ae_in(ae_in),
    .rd_pkt_rdy(rd_pkt_rdy), .stat_vec(stat_vec)
  );

  task automatic compare(input string tag);
    logic [3:0] exp_vec;
    logic       exp_rdy;
    for (int i = 0; i < NQ; i++) exp_vec[i] = (m_cnt[i] != 0);
    exp_rdy = pkt_mode && exp_vec[rd_q];
    if (!pkt_mode) exp_vec = ae_in;
    vectors++;
    if (stat_vec !== exp_vec) begin
      errors++;
      $display("FAIL %s stat_vec actual=%b expected=%b", tag, stat_vec, exp_vec);
    end
    vectors++;
    if (rd_pkt_rdy !== exp_rdy) begin
      errors++;
      $display("FAIL %s rd_pkt_rdy actual=%b expected=%b", tag, rd_pkt_rdy, exp_rdy);
    end
  endtask

  // drive one vector at the falling edge, model the rising edge, compare at the next falling edge
  task automatic step(input bit we, input logic [1:0] wq, input logic [1:0] wm,
                      input bit re, input logic [1:0] rq, input logic [1:0] rm,
                      input bit pr, input logic [1:0] pq, input string tag);
    bit inc, dec;
    wr_en = we; wr_q = wq; wr_mark = wm;
    rd_en = re; rd_q = rq; rd_mark = rm;
    prst_en = pr; prst_q = pq;
    @(posedge clk);
    for (int i = 0; i < NQ; i++) begin
      inc = we && wq == 2'(i) && wm[1] && (wm[0] || m_wopen[i]);
      dec = re && rq == 2'(i) && rm[1] && (rm[0] || m_ropen[i]);
      if (pr && pq == 2'(i)) begin
        m_cnt[i] = 0; m_wopen[i] = 0; m_ropen[i] = 0;
      end else begin
        if (inc && !dec && m_cnt[i] < CMAX) m_cnt[i]++;
        if (dec && !inc && m_cnt[i] > 0) m_cnt[i]--;
        if (we && wq == 2'(i)) m_wopen[i] = wm[1] ? 1'b0 : (wm[0] ? 1'b1 : m_wopen[i]);
        if (re && rq == 2'(i)) m_ropen[i] = rm[1] ? 1'b0 : (rm[0] ? 1'b1 : m_ropen[i]);
      end
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic wr(input logic [1:0] q, input logic [1:0] m, input string tag);
    step(1, q, m, 0, rd_q, 2'b00, 0, 2'd0, tag);
  endtask

  task automatic rd(input logic [1:0] q, input logic [1:0] m, input string tag);
    step(0, 2'd0, 2'b00, 1, q, m, 0, 2'd0, tag);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pkt_mode = 1'b1; ae_in = 4'b0000;
    wr_en = 0; rd_en = 0; prst_en = 0;
    wr_q = 0; rd_q = 0; prst_q = 0; wr_mark = 0; rd_mark = 0;
    for (int i = 0; i < NQ; i++) begin m_cnt[i] = 0; m_wopen[i] = 0; m_ropen[i] = 0; end
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // R3: orphan end marker and unmarked words
    wr(2'd0, 2'b10, "R3");
    wr(2'd0, 2'b00, "R3");
    // R2: multi-word packet on queue 1, single-word packet on queue 2
    wr(2'd1, 2'b01, "R2");
    wr(2'd1, 2'b00, "R2");
    wr(2'd1, 2'b10, "R2");
    wr(2'd2, 2'b11, "R2");
    // R7: read select over every queue
    for (int q = 0; q < NQ; q++) step(0, 0, 0, 0, 2'(q), 0, 0, 0, "R7");
    // R8: mode off passes the external vector
    pkt_mode = 1'b0; ae_in = 4'b1010;
    step(0, 0, 0, 0, 2'd1, 0, 0, 0, "R8");
    ae_in = 4'b0101;
    step(0, 0, 0, 0, 2'd2, 0, 0, 0, "R8");
    pkt_mode = 1'b1;
    step(0, 0, 0, 0, 2'd1, 0, 0, 0, "R8");
    // R5: simultaneous completion on queue 1
    step(1, 2'd1, 2'b11, 1, 2'd1, 2'b11, 0, 0, "R5");
    // R4: read out queue 1 packet word by word
    rd(2'd1, 2'b01, "R4");
    rd(2'd1, 2'b00, "R4");
    rd(2'd1, 2'b10, "R4");
    // R6: saturation then drain past zero
    for (int k = 0; k < CMAX + 2; k++) wr(2'd3, 2'b11, "R6");
    for (int k = 0; k < CMAX + 1; k++) rd(2'd3, 2'b11, "R6");
    wr(2'd3, 2'b11, "R6");
    // R9: partial reset wins over same-cycle write, leaves other queues, drops open packet
    wr(2'd0, 2'b11, "R9");
    step(1, 2'd2, 2'b11, 0, 2'd2, 0, 1, 2'd2, "R9");
    wr(2'd2, 2'b01, "R9");
    step(0, 0, 0, 0, 2'd2, 0, 1, 2'd2, "R9");
    wr(2'd2, 2'b10, "R9");
    // R10: sweep of mixed traffic across all queues
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[31:28] == 4'hF) pkt_mode = ~pkt_mode;
      ae_in = r[27:24];
      step(r[0], r[2:1], r[4:3], r[5], r[7:6], r[9:8],
           (r[15:10] == 6'd0), r[17:16], "R10");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule